// File: doc/BRIEF.md
# Controlled-Clock Advance Arbiter

This block decides when a controlled clock domain may take its next edge. It is shared by a set of peers that all run on one free-running base clock. Each peer raises its own ready line when it can accept the next controlled edge. When every peer is ready in the same base cycle, the block pulses a single edge enable on the following cycle. That pulse goes to all peers. They treat it as the controlled edge and qualify their controlled-domain registers with it. The clock is never gated.

One extra peer slot can be filled by an internal software pacing agent. Host code loads a number of edges it wants to allow. The agent holds its ready line high until that many edges have passed, then drops it. This lets the host step the controlled clock by an exact number of cycles. The block also keeps a wrapping count of all edges it has produced.

Top module: `ccadv_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `edge_en` is 0, `edge_count` is 0 and `sw_rdy` is 0 (no software edges outstanding).
- R2: `edge_en` is 1 in cycle t+1 exactly when, in cycle t, every bit of `hw_rdy` and `sw_rdy` was 1 and `edge_en` was 0. In every other case it is 0.
- R3: `edge_en` is never 1 in two consecutive cycles. A ready level seen in an edge cycle is consumed by that edge, so a peer that holds ready continuously gets one edge every two cycles.
- R4: Any single ready line at 0 blocks the edge, whichever peer it belongs to. While the software agent has no edges outstanding, no edge is produced even if all `hw_rdy` bits are 1.
- R5: A cycle with `sw_load` = 1 sets the agent's outstanding count to `sw_count`. `sw_rdy` is 1 exactly while the outstanding count is nonzero. Each `edge_en` cycle with a nonzero count and no load lowers the count by one, so a load of K followed by free-running peers yields exactly K edges.
- R6: When `sw_load` falls in the same cycle as `edge_en`, the new count replaces the old one and that edge is not deducted from the new count.
- R7: `edge_count` (CNT_W bits, default 32) rises by one in the cycle after each `edge_en` cycle, holds otherwise, and wraps from all ones to 0.
- R8: Loading `sw_count` = 0 cancels any outstanding software edges, and `sw_rdy` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| hw_rdy | input | NUM_HW | Per-peer ready lines of the hardware peers |
| sw_load | input | 1 | Strobe: load a new outstanding edge count into the software agent |
| sw_count | input | REQ_W | Number of edges to allow on `sw_load` |
| sw_rdy | output | 1 | Ready line of the software agent (1 while edges are outstanding) |
| edge_en | output | 1 | One-cycle controlled edge enable, broadcast to all peers |
| edge_count | output | CNT_W | Wrapping count of produced edges |

## Verification
The two functions that can collide are the reload of the software agent and the consumption of an edge. The same base cycle can carry both `sw_load` and `edge_en`. The bench waits until it sees an edge pulse and then presents a load in that very cycle. It judges the result by counting the edges that follow with all hardware peers held ready. That count must equal the new load exactly. A load of zero in an edge cycle must also leave `sw_rdy` low on the next cycle. Random traffic that mixes loads with ready toggling hits the same collision many more times, and a cycle-exact model checks every one of them.

// File: rtl/ccadv_pkg.sv
package ccadv_pkg;
  localparam int unsigned DEF_NUM_HW = 3;
  localparam int unsigned DEF_CNT_W  = 32;
  localparam int unsigned DEF_REQ_W  = 16;

  function automatic int unsigned peer_total(input int unsigned num_hw, input bit use_sw);
    return num_hw + (use_sw ? 1 : 0);
  endfunction
endpackage

// File: rtl/ccadv_sw_agent.sv
module ccadv_sw_agent #(
  parameter int unsigned REQ_W = ccadv_pkg::DEF_REQ_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REQ_W-1:0] count,
  input  logic             edge_en,
  output logic             rdy
);
  logic [REQ_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= count;
    end else if (edge_en && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign rdy = (remain_q != '0);

  // R5
  sw_decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && $past(edge_en) && $past(remain_q) != '0)
      |-> remain_q == $past(remain_q) - 1'b1);
  // R6
  sw_reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> remain_q == $past(count));
  // R8
  sw_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (load && count == '0) |=> !rdy);
endmodule

// File: rtl/ccadv_ready_join.sv
module ccadv_ready_join #(
  parameter int unsigned NUM_PEERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PEERS-1:0] rdy_vec,
  output logic                 edge_en
);
  logic all_rdy;
  assign all_rdy = &rdy_vec;

  always_ff @(posedge clk) begin
    if (rst) edge_en <= 1'b0;
    else     edge_en <= all_rdy & ~edge_en;
  end

  // R2
  join_all_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && edge_en) |-> $past(&rdy_vec));
  // R3
  join_no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    edge_en |=> !edge_en);
endmodule

// File: rtl/ccadv_edge_tally.sv
module ccadv_edge_tally #(
  parameter int unsigned CNT_W = ccadv_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_en,
  output logic [CNT_W-1:0] tally
);
  always_ff @(posedge clk) begin
    if (rst)          tally <= '0;
    else if (edge_en) tally <= tally + 1'b1;
  end

  // R7
  tally_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(edge_en)) |-> tally == $past(tally) + 1'b1);
  // R7
  tally_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(edge_en)) |-> $stable(tally));
endmodule

// File: rtl/ccadv_arbiter.sv
module ccadv_arbiter #(
  parameter int unsigned NUM_HW = ccadv_pkg::DEF_NUM_HW,
  parameter int unsigned CNT_W  = ccadv_pkg::DEF_CNT_W,
  parameter int unsigned REQ_W  = ccadv_pkg::DEF_REQ_W,
  parameter bit          USE_SW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_HW-1:0] hw_rdy,
  input  logic              sw_load,
  input  logic [REQ_W-1:0]  sw_count,
  output logic              sw_rdy,
  output logic              edge_en,
  output logic [CNT_W-1:0]  edge_count
);
  localparam int unsigned NUM_PEERS = ccadv_pkg::peer_total(NUM_HW, USE_SW);

  logic [NUM_PEERS-1:0] rdy_vec;

  generate
    if (USE_SW) begin : g_sw
      ccadv_sw_agent #(.REQ_W(REQ_W)) u_sw (
        .clk(clk), .rst(rst), .load(sw_load), .count(sw_count),
        .edge_en(edge_en), .rdy(sw_rdy)
      );
      assign rdy_vec = {sw_rdy, hw_rdy};
    end else begin : g_no_sw
      assign sw_rdy  = 1'b0;
      assign rdy_vec = hw_rdy;
    end
  endgenerate

  ccadv_ready_join #(.NUM_PEERS(NUM_PEERS)) u_join (
    .clk(clk), .rst(rst), .rdy_vec(rdy_vec), .edge_en(edge_en)
  );

  ccadv_edge_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .edge_en(edge_en), .tally(edge_count)
  );

  // R4
  arb_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&hw_rdy) || !sw_rdy) |=> !edge_en);
  // R1
  arb_reset_chk: assert property (@(posedge clk)
    rst |=> (!edge_en && edge_count == '0));
endmodule

// File: tb/test_ccadv_arbiter.sv
module test_ccadv_arbiter;
  localparam int unsigned NUM_HW = 3;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned REQ_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_HW-1:0] hw_rdy = '0;
  logic              sw_load = 1'b0;
  logic [REQ_W-1:0]  sw_count = '0;
  logic              sw_rdy, edge_en;
  logic [CNT_W-1:0]  edge_count;

  int checks = 0, fails = 0;
  int seen_edges;
  logic              m_en;
  logic [CNT_W-1:0]  m_cnt;
  logic [REQ_W-1:0]  m_rem;

  always #2ns clk = ~clk;

  ccadv_arbiter #(.NUM_HW(NUM_HW), .CNT_W(CNT_W), .REQ_W(REQ_W), .USE_SW(1'b1)) i_ccadv_arbiter (
    .clk(clk), .rst(rst), .hw_rdy(hw_rdy), .sw_load(sw_load), .sw_count(sw_count),
    .sw_rdy(sw_rdy), .edge_en(edge_en), .edge_count(edge_count)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic next_en(input logic en, input logic [NUM_HW-1:0] h, input logic [REQ_W-1:0] rem);
    return (&h) && (rem != '0) && !en;
  endfunction

  function automatic logic [REQ_W-1:0] next_rem(input logic ld, input logic [REQ_W-1:0] c,
                                               input logic en, input logic [REQ_W-1:0] rem);
    if (ld) return c;
    if (en && rem != '0) return rem - 1'b1;
    return rem;
  endfunction

  // At a negedge: compare, drive, advance one cycle, update model, return at next negedge.
  task automatic step(input logic [NUM_HW-1:0] h, input logic ld, input logic [REQ_W-1:0] c);
    logic              n_en;
    logic [REQ_W-1:0]  n_rem;
    check("R2/R3 edge_en", edge_en, m_en);
    check("R7 edge_count", edge_count, m_cnt);
    check("R5 sw_rdy", sw_rdy, m_rem != '0);
    if (edge_en) seen_edges++;
    hw_rdy = h; sw_load = ld; sw_count = c;
    @(posedge clk);
    n_en  = next_en(m_en, h, m_rem);
    n_rem = next_rem(ld, c, m_en, m_rem);
    m_cnt = m_cnt + (m_en ? 1'b1 : 1'b0);
    m_en  = n_en;
    m_rem = n_rem;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = 1'b0; m_cnt = '0; m_rem = '0;
    hw_rdy = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with all hardware peers ready
    check("R1 edge_en in reset", edge_en, 0);
    check("R1 edge_count in reset", edge_count, 0);
    check("R1 sw_rdy in reset", sw_rdy, 0);
    rst = 1'b0;

    // R4: software agent idle blocks edges
    seen_edges = 0;
    repeat (6) step('1, 1'b0, '0);
    check("R4 no edge while agent idle", seen_edges, 0);

    // R5: load 3, exactly 3 edges
    step('1, 1'b1, 8'd3);
    seen_edges = 0;
    repeat (14) step('1, 1'b0, '0);
    check("R5 edges after load of 3", seen_edges, 3);
    check("R5 sw_rdy low after use", sw_rdy, 0);

    // R4: one hardware peer low blocks
    step('1, 1'b1, 8'd4);
    seen_edges = 0;
    repeat (8) step(3'b101, 1'b0, '0);
    check("R4 peer low blocks edge", seen_edges, 0);
    // R3: continuous ready gives alternate pulses
    seen_edges = 0;
    repeat (9) step('1, 1'b0, '0);
    check("R3 alternate edges", seen_edges, 4);

    // R6: load coinciding with an edge
    step('1, 1'b1, 8'd20);
    while (edge_en !== 1'b1) step('1, 1'b0, '0);
    step('1, 1'b1, 8'd5);
    seen_edges = 0;
    repeat (14) step('1, 1'b0, '0);
    check("R6 edges after load in edge cycle", seen_edges, 5);

    // R8: cancel in an edge cycle
    step('1, 1'b1, 8'd9);
    while (edge_en !== 1'b1) step('1, 1'b0, '0);
    step('1, 1'b1, 8'd0);
    check("R8 sw_rdy after cancel", sw_rdy, 0);
    seen_edges = 0;
    repeat (5) step('1, 1'b0, '0);
    check("R8 no edge after cancel", seen_edges, 0);

    // R7: wrap of the edge counter
    step('1, 1'b1, 8'd255);
    while (edge_count !== '1) step('1, 1'b0, '0);
    while (edge_count === '1) step('1, 1'b0, '0);
    check("R7 counter wraps to zero", edge_count, 0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [NUM_HW-1:0] h;
      logic ld;
      for (int b = 0; b < NUM_HW; b++) h[b] = ($urandom % 8) != 0;
      ld = ($urandom % 20) == 0;
      step(h, ld, REQ_W'($urandom % 12));
    end

    // R1: reset again mid-run
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 edge_en after reset", edge_en, 0);
    check("R1 edge_count after reset", edge_count, 0);
    check("R1 sw_rdy after reset", sw_rdy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule